// File: doc/BRIEF.md
# Scheduled Serial Word Shifter

This block sends a control word out on a single pin at a chosen moment of synchronized time. The host loads one 16-bit segment into each of several unit registers through a valid/ready load port. It then sets a start time, a bit period, a repetition count, a gap length, an idle level and the number of units to chain, and pulses `arm`. Once the time input reaches the start time, the block puts the segments on the pin. The segments go out in unit order with no space between them, so two chained units form one 32-bit word.

A bit goes out most significant bit first and stays on the pin for a programmable number of clock cycles. Between repetitions the pin rests at the idle level for a programmable number of cycles. When the last repetition ends, the block raises `done` and holds the pin at the idle level. The configuration is taken once, at the arm pulse, so the host may change the configuration inputs during a transfer without effect.

Back-pressure on the load port: `ld_ready` is high only while the block is not busy. A word is stored only in a cycle where both `ld_valid` and `ld_ready` are high. A load offered while the block is busy is not taken. It stays pending at the host and has no effect on the transfer in progress.

Top module: `ssw_shift_out`

## Requirements
- R1: After reset `ser_out` is 0, `busy` is 0, `done` is 0 and `ld_ready` is 1.
- R2: On a clock edge with `ld_valid` and `ld_ready` both high, `ld_data` is stored as the segment of unit `ld_sel`, where unit 0 is sent first. `ld_ready` is low while `busy` is high, and a load offered then leaves the stored segments unchanged.
- R3: A high `arm` at an edge while not busy captures all configuration inputs and sets `busy`. The pin shows the captured idle level until the trigger. An `arm` seen while busy has no effect, and neither does any configuration change made while busy.
- R4: Take the first edge after the arm edge at which `now_time - start_time`, computed modulo 2^32, has a clear top bit. The first data bit appears on the pin in the cycle that follows this edge. A start time already reached therefore triggers on the edge right after the arm edge.
- R5: Each segment is sent with bit 15 first and bit 0 last. Every bit stays on the pin for `cfg_bit_ticks` cycles, and a setting of 0 acts as 1.
- R6: Units 0 to U-1 are sent back to back with no idle cycle between them. U is `cfg_units`, where 0 acts as 1 and any value above the unit count acts as the unit count.
- R7: The chained word is sent `cfg_reps` times, where 0 acts as 1.
- R8: Between two repetitions the pin holds the idle level for exactly `cfg_gap_ticks` cycles. A gap of 0 sends the repetitions back to back.
- R9: In the cycle after the last bit period ends, `busy` is 0, `done` is 1 and the pin is at the idle level. `done` falls when the next arm is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| now_time | input | 32 | Synchronized time count |
| ld_valid | input | 1 | Load request for one segment |
| ld_ready | output | 1 | Load accepted this cycle if valid |
| ld_sel | input | 1 | Unit receiving the segment |
| ld_data | input | 16 | Segment value |
| cfg_start_time | input | 32 | Time at which sending begins |
| cfg_bit_ticks | input | 8 | Clock cycles per bit |
| cfg_gap_ticks | input | 8 | Idle cycles between repetitions |
| cfg_reps | input | 8 | Number of repetitions |
| cfg_units | input | 2 | Number of chained units |
| cfg_idle_level | input | 1 | Pin level when not sending |
| arm | input | 1 | Captures the configuration and waits for the start time |
| ser_out | output | 1 | Serial output pin |
| busy | output | 1 | Armed or sending |
| done | output | 1 | Last repetition finished |

## Verification
Three conditions are hard to reach from the ports. The first is the seam between the last bit of one unit and the first bit of the next. The second is the seam at the end of a repetition, where the gap may be zero, a bit period may be one cycle long and the unit count may need clamping. The third is a load or re-arm that arrives while the transfer is still running. The bench sweeps unit count, bit period, repetition count, gap, idle level and a start time either in the past or in the future. For each combination it compares every cycle of the pin against a position computed by arithmetic. In every run it also offers an inverted load and a second arm with different settings while busy, so any leak would show up in the waveform.

// File: rtl/ssw_pkg.sv
package ssw_pkg;
  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_WAIT  = 2'd1,
    SQ_SHIFT = 2'd2,
    SQ_GAP   = 2'd3
  } sq_state_t;
endpackage

// File: rtl/ssw_time_match.sv
module ssw_time_match #(
  parameter int TIME_W = 32
) (
  input  logic [TIME_W-1:0] now_time,
  input  logic [TIME_W-1:0] start_time,
  output logic              reached
);
  logic [TIME_W-1:0] diff;
  // wrap-safe: reached when the modular difference is non-negative
  always_comb begin
    diff    = now_time - start_time;
    reached = ~diff[TIME_W-1];
  end
endmodule

// File: rtl/ssw_bit_timer.sv
module ssw_bit_timer #(
  parameter int TICK_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [TICK_W-1:0] hold_ticks,
  output logic              bit_last
);
  logic [TICK_W-1:0] cnt_q;

  assign bit_last = run && ((cnt_q + TICK_W'(1)) == hold_ticks);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (!run || bit_last) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + TICK_W'(1);
    end
  end

  AST_TICK_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt_q < hold_ticks)); // R5
endmodule

// File: rtl/ssw_word_bank.sv
module ssw_word_bank #(
  parameter int WORD_W    = 16,
  parameter int NUM_UNITS = 2,
  localparam int SEL_W    = (NUM_UNITS > 1) ? $clog2(NUM_UNITS) : 1,
  localparam int BIT_W    = $clog2(WORD_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_valid,
  input  logic              ld_ready,
  input  logic [SEL_W-1:0]  ld_sel,
  input  logic [WORD_W-1:0] ld_data,
  input  logic [SEL_W-1:0]  unit_idx,
  input  logic [BIT_W-1:0]  bit_idx,
  output logic              bit_val
);
  logic [NUM_UNITS-1:0][WORD_W-1:0] data_q;
  logic [BIT_W-1:0]                 pos;

  for (genvar g = 0; g < NUM_UNITS; g++) begin : g_unit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        data_q[g] <= '0;
      end else if (ld_valid && ld_ready && (ld_sel == SEL_W'(g))) begin
        data_q[g] <= ld_data;
      end
    end
  end

  always_comb begin
    pos     = BIT_W'(WORD_W - 1) - bit_idx;
    bit_val = data_q[unit_idx][pos];
  end

  AST_LOAD_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_ready |=> $stable(data_q)); // R2
endmodule

// File: rtl/ssw_sequencer.sv
module ssw_sequencer
  import ssw_pkg::*;
#(
  parameter int WORD_W    = 16,
  parameter int NUM_UNITS = 2,
  parameter int TIME_W    = 32,
  parameter int TICK_W    = 8,
  parameter int GAP_W     = 8,
  parameter int REP_W     = 8,
  localparam int SEL_W    = (NUM_UNITS > 1) ? $clog2(NUM_UNITS) : 1,
  localparam int UCNT_W   = $clog2(NUM_UNITS + 1),
  localparam int BIT_W    = $clog2(WORD_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arm,
  input  logic [TIME_W-1:0] cfg_start_time,
  input  logic [TICK_W-1:0] cfg_bit_ticks,
  input  logic [GAP_W-1:0]  cfg_gap_ticks,
  input  logic [REP_W-1:0]  cfg_reps,
  input  logic [UCNT_W-1:0] cfg_units,
  input  logic              cfg_idle_level,
  input  logic              reached,
  input  logic              bit_last,
  output logic [TIME_W-1:0] start_q,
  output logic [TICK_W-1:0] hold_q,
  output logic [SEL_W-1:0]  unit_q,
  output logic [BIT_W-1:0]  bit_q,
  output logic              shifting,
  output logic              idle_q,
  output logic              busy,
  output logic              done
);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(WORD_W - 1);

  sq_state_t         st;
  logic [GAP_W-1:0]  gap_ticks_q;
  logic [GAP_W-1:0]  gap_q;
  logic [REP_W-1:0]  reps_q;
  logic [REP_W-1:0]  rep_q;
  logic [UCNT_W-1:0] units_q;
  logic              done_q;
  logic              last_unit;
  logic              last_rep;
  logic [UCNT_W-1:0] units_eff;

  always_comb begin
    if (cfg_units == '0) begin
      units_eff = UCNT_W'(1);
    end else if (cfg_units > UCNT_W'(NUM_UNITS)) begin
      units_eff = UCNT_W'(NUM_UNITS);
    end else begin
      units_eff = cfg_units;
    end
  end

  assign last_unit = (UCNT_W'(unit_q) + UCNT_W'(1)) == units_q;
  assign last_rep  = (rep_q + REP_W'(1)) == reps_q;
  assign shifting  = (st == SQ_SHIFT);
  assign busy      = (st != SQ_IDLE);
  assign done      = done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= SQ_IDLE;
      start_q     <= '0;
      hold_q      <= TICK_W'(1);
      gap_ticks_q <= '0;
      gap_q       <= '0;
      reps_q      <= REP_W'(1);
      rep_q       <= '0;
      units_q     <= UCNT_W'(1);
      unit_q      <= '0;
      bit_q       <= '0;
      idle_q      <= 1'b0;
      done_q      <= 1'b0;
    end else begin
      case (st)
        SQ_IDLE: begin
          if (arm) begin
            start_q     <= cfg_start_time;
            hold_q      <= (cfg_bit_ticks == '0) ? TICK_W'(1) : cfg_bit_ticks;
            gap_ticks_q <= cfg_gap_ticks;
            reps_q      <= (cfg_reps == '0) ? REP_W'(1) : cfg_reps;
            units_q     <= units_eff;
            idle_q      <= cfg_idle_level;
            done_q      <= 1'b0;
            st          <= SQ_WAIT;
          end
        end
        SQ_WAIT: begin
          if (reached) begin
            unit_q <= '0;
            bit_q  <= '0;
            rep_q  <= '0;
            st     <= SQ_SHIFT;
          end
        end
        SQ_SHIFT: begin
          if (bit_last) begin
            if (bit_q == LAST_BIT) begin
              bit_q <= '0;
              if (last_unit) begin
                unit_q <= '0;
                if (last_rep) begin
                  done_q <= 1'b1;
                  st     <= SQ_IDLE;
                end else begin
                  rep_q <= rep_q + REP_W'(1);
                  if (gap_ticks_q != '0) begin
                    gap_q <= '0;
                    st    <= SQ_GAP;
                  end
                end
              end else begin
                unit_q <= unit_q + SEL_W'(1);
              end
            end else begin
              bit_q <= bit_q + BIT_W'(1);
            end
          end
        end
        SQ_GAP: begin
          if ((gap_q + GAP_W'(1)) == gap_ticks_q) begin
            st <= SQ_SHIFT;
          end else begin
            gap_q <= gap_q + GAP_W'(1);
          end
        end
        default: st <= SQ_IDLE;
      endcase
    end
  end

  AST_ARM_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && arm) |=> ($stable(reps_q) && $stable(hold_q) && $stable(start_q))); // R3
  AST_WAIT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (st == SQ_WAIT && !reached) |=> (st == SQ_WAIT)); // R4
  AST_BIT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (shifting && !bit_last) |=> ($stable(bit_q) && $stable(unit_q))); // R5
  AST_UNIT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (shifting && bit_last && bit_q != LAST_BIT) |=> $stable(unit_q)); // R6
  AST_REP_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (shifting || st == SQ_GAP) |-> (rep_q < reps_q)); // R7
  AST_GAP_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (st == SQ_GAP) |-> (gap_ticks_q != '0)); // R8
  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> !busy); // R9
endmodule

// File: rtl/ssw_shift_out.sv
module ssw_shift_out #(
  parameter int WORD_W    = 16,
  parameter int NUM_UNITS = 2,
  parameter int TIME_W    = 32,
  parameter int TICK_W    = 8,
  parameter int GAP_W     = 8,
  parameter int REP_W     = 8,
  localparam int SEL_W    = (NUM_UNITS > 1) ? $clog2(NUM_UNITS) : 1,
  localparam int UCNT_W   = $clog2(NUM_UNITS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TIME_W-1:0] now_time,
  input  logic              ld_valid,
  output logic              ld_ready,
  input  logic [SEL_W-1:0]  ld_sel,
  input  logic [WORD_W-1:0] ld_data,
  input  logic [TIME_W-1:0] cfg_start_time,
  input  logic [TICK_W-1:0] cfg_bit_ticks,
  input  logic [GAP_W-1:0]  cfg_gap_ticks,
  input  logic [REP_W-1:0]  cfg_reps,
  input  logic [UCNT_W-1:0] cfg_units,
  input  logic              cfg_idle_level,
  input  logic              arm,
  output logic              ser_out,
  output logic              busy,
  output logic              done
);
  localparam int BIT_W = $clog2(WORD_W);

  logic [TIME_W-1:0] start_q;
  logic [TICK_W-1:0] hold_q;
  logic [SEL_W-1:0]  unit_q;
  logic [BIT_W-1:0]  bit_q;
  logic              shifting;
  logic              idle_q;
  logic              reached;
  logic              bit_last;
  logic              bank_bit;

  assign ld_ready = ~busy;
  assign ser_out  = shifting ? bank_bit : idle_q;

  ssw_time_match #(.TIME_W(TIME_W)) u_match (
    .now_time   (now_time),
    .start_time (start_q),
    .reached    (reached)
  );

  ssw_bit_timer #(.TICK_W(TICK_W)) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .run        (shifting),
    .hold_ticks (hold_q),
    .bit_last   (bit_last)
  );

  ssw_word_bank #(.WORD_W(WORD_W), .NUM_UNITS(NUM_UNITS)) u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .ld_valid (ld_valid),
    .ld_ready (ld_ready),
    .ld_sel   (ld_sel),
    .ld_data  (ld_data),
    .unit_idx (unit_q),
    .bit_idx  (bit_q),
    .bit_val  (bank_bit)
  );

  ssw_sequencer #(
    .WORD_W(WORD_W), .NUM_UNITS(NUM_UNITS), .TIME_W(TIME_W),
    .TICK_W(TICK_W), .GAP_W(GAP_W), .REP_W(REP_W)
  ) u_seq (
    .clk            (clk),
    .rst_n          (rst_n),
    .arm            (arm),
    .cfg_start_time (cfg_start_time),
    .cfg_bit_ticks  (cfg_bit_ticks),
    .cfg_gap_ticks  (cfg_gap_ticks),
    .cfg_reps       (cfg_reps),
    .cfg_units      (cfg_units),
    .cfg_idle_level (cfg_idle_level),
    .reached        (reached),
    .bit_last       (bit_last),
    .start_q        (start_q),
    .hold_q         (hold_q),
    .unit_q         (unit_q),
    .bit_q          (bit_q),
    .shifting       (shifting),
    .idle_q         (idle_q),
    .busy           (busy),
    .done           (done)
  );

  AST_READY_WHEN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ld_ready); // R9
endmodule

// File: tb/sim_ssw_shift_out.sv
`timescale 1ns/1ps
module sim_ssw_shift_out;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] now_time = 32'h7000_0000;
  logic        ld_valid = 1'b0;
  logic        ld_ready;
  logic [0:0]  ld_sel = 1'b0;
  logic [15:0] ld_data = '0;
  logic [31:0] cfg_start_time = '0;
  logic [7:0]  cfg_bit_ticks = '0;
  logic [7:0]  cfg_gap_ticks = '0;
  logic [7:0]  cfg_reps = '0;
  logic [1:0]  cfg_units = '0;
  logic        cfg_idle_level = 1'b0;
  logic        arm = 1'b0;
  logic        ser_out;
  logic        busy;
  logic        done;

  int  checks = 0;
  int  errors = 0;
  bit  finished = 1'b0;

  always #2 clk = ~clk;
  always @(posedge clk) now_time <= now_time + 32'd1;

  ssw_shift_out u0 (
    .clk(clk), .rst_n(rst_n), .now_time(now_time),
    .ld_valid(ld_valid), .ld_ready(ld_ready), .ld_sel(ld_sel), .ld_data(ld_data),
    .cfg_start_time(cfg_start_time), .cfg_bit_ticks(cfg_bit_ticks),
    .cfg_gap_ticks(cfg_gap_ticks), .cfg_reps(cfg_reps), .cfg_units(cfg_units),
    .cfg_idle_level(cfg_idle_level), .arm(arm),
    .ser_out(ser_out), .busy(busy), .done(done)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // expected pin level at sample n (n-th falling edge after the arm edge)
  function automatic logic exp_pin(int n, int t, int hold, int ue, int re, int gap,
                                   logic idle, logic [15:0] w0, logic [15:0] w1,
                                   output string tag);
    int seg, per, tot, k, r, w, bi, u, b;
    seg = ue * 16 * hold;
    per = seg + gap;
    tot = re * seg + (re - 1) * gap;
    if (n <= t) begin tag = "R4"; return idle; end
    k = n - t - 1;
    if (k >= tot) begin tag = "R9"; return idle; end
    r = k / per;
    w = k % per;
    if (w >= seg) begin tag = "R8"; return idle; end
    bi = w / hold;
    u  = bi / 16;
    b  = bi % 16;
    if (r > 0) tag = "R7";
    else if (u > 0) tag = "R6";
    else tag = "R5";
    return (u == 0) ? w0[15-b] : w1[15-b];
  endfunction

  task automatic run_one(int ucfg, int bt, int reps, int gap, int d, logic idle, int idx);
    int ue, hold, re, t, tot, nmax, bad_n;
    logic [15:0] w0, w1;
    logic e, got_bad, bad_exp, bad_act;
    string tag, bad_tag;
    ue   = (ucfg == 0) ? 1 : ((ucfg > 2) ? 2 : ucfg);
    hold = (bt == 0) ? 1 : bt;
    re   = (reps == 0) ? 1 : reps;
    t    = (d < 1) ? 1 : d;
    tot  = re * ue * 16 * hold + (re - 1) * gap;
    nmax = t + tot + 3;
    w0 = 16'hA5C3 ^ 16'(idx * 16'h1357);
    w1 = 16'h3C96 ^ 16'(idx * 16'h0B1D);
    // R2: load both segments through the handshake
    @(negedge clk);
    ld_valid = 1'b1; ld_sel = 1'b0; ld_data = w0;
    @(negedge clk);
    ld_sel = 1'b1; ld_data = w1;
    @(negedge clk);
    ld_valid = 1'b0;
    cfg_units = 2'(ucfg); cfg_bit_ticks = 8'(bt); cfg_reps = 8'(reps);
    cfg_gap_ticks = 8'(gap); cfg_idle_level = idle;
    cfg_start_time = now_time + 32'(d);
    arm = 1'b1;
    got_bad = 1'b0; bad_n = 0; bad_exp = 1'b0; bad_act = 1'b0; bad_tag = "";
    for (int n = 1; n <= nmax; n++) begin
      @(negedge clk);
      e = exp_pin(n, t, hold, ue, re, gap, idle, w0, w1, tag);
      if (!got_bad && ser_out !== e) begin
        got_bad = 1'b1; bad_n = n; bad_exp = e; bad_act = ser_out; bad_tag = tag;
      end
      if (n == 1) begin
        check(busy === 1'b1 && done === 1'b0, "R3", "busy/done after arm",
              {busy, done}, 2'b10);
        check(ld_ready === 1'b0, "R2", "ld_ready while busy", ld_ready, 0);
        arm = 1'b0;
        ld_valid = 1'b1; ld_sel = 1'b0; ld_data = ~w0;   // must be refused
      end else if (n == 2) begin
        ld_valid = 1'b0;
        arm = 1'b1; cfg_reps = 8'd7; cfg_bit_ticks = 8'd5; // must be ignored (R3)
        cfg_idle_level = ~idle;
      end else if (n == 3) begin
        arm = 1'b0;
      end
    end
    if (got_bad)
      $display("FAIL %s pin mismatch run %0d sample %0d actual=%0d expected=%0d",
               bad_tag, idx, bad_n, bad_act, bad_exp);
    checks++;
    if (got_bad) errors++;
    check(busy === 1'b0 && done === 1'b1 && ser_out === idle, "R9",
          "end state busy/done/pin", {busy, done, ser_out}, {2'b01, idle});
  endtask

  initial begin
    int idx;
    idx = 0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(ser_out === 1'b0 && busy === 1'b0 && done === 1'b0 && ld_ready === 1'b1,
          "R1", "reset outputs", {ser_out, busy, done, ld_ready}, 4'b0001);
    rst_n = 1'b1;
    @(negedge clk);
    for (int u = 0; u < 4; u++)
      for (int bt = 0; bt < 4; bt++)
        for (int ri = 0; ri < 3; ri++)
          for (int gi = 0; gi < 2; gi++)
            for (int di = 0; di < 2; di++)
              for (int il = 0; il < 2; il++) begin
                run_one(u, bt, (ri == 0) ? 0 : ((ri == 1) ? 1 : 3), gi * 2,
                        (di == 0) ? -2 : 3, il[0], idx);
                idx++;
              end
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule